// File: doc/BRIEF.md
# Bus Cycle Breakpoint Comparator

This block watches every completed cycle on a processor bus and compares it with two breakpoint channels. Each channel holds a 32-bit address, an address mask and a qualifier word. The qualifier word selects instruction fetch or data access, read or write, and operand size. Channel 1 can also require a 32-bit data value under a data mask. When a cycle satisfies a channel, that channel's sticky hit flag is set and a one-cycle break request goes out. Cycles driven by an external bus master can be included with a global enable. Such cycles are compared with the size ignored, are treated as data accesses, and use only the address lines the external master drives. For these cycles a separate sticky flag is also set per channel.

Software loads the registers through a single write port: `wr_sel` picks the register and `wr_data` carries the value. The flags are cleared through a write-one-to-clear strobe. The bus side offers one cycle to the comparator per clock in which `bus_valid` is high.

Register select codes are: 0 ch0 address, 1 ch0 mask, 2 ch0 qualifier, 3 ch1 address, 4 ch1 mask, 5 ch1 qualifier, 6 ch1 data value, 7 ch1 data mask, 8 external enable (bit 0).

The qualifier word has these fields:
- bits [1:0] fetch/data: 00 don't care, 01 fetch, 10 data, 11 either.
- bits [3:2] read/write: 00 don't care, 01 read, 10 write, 11 either.
- bits [5:4] size: 00 any, 01 byte, 10 word, 11 long.
- bit [6] data condition, which has an effect on channel 1 only.

The bus size code on `bus_size` is 00 byte, 01 word and 10 long. The value 11 is treated as long.

Top module: `bus_break_cmp`

## Requirements
- R1: After reset, `hit_flag`, `ext_flag` and `brk_req` are 0. Every register is 0, so both channels are off.
- R2: On a longword cycle, address bits 1:0 are left out of the compare. Bits 31:2 must be equal.
- R3: On a word cycle, only address bit 0 is left out of the compare. On a byte cycle, all 32 bits are compared.
- R4: An address mask bit of 1 removes that bit from the compare. A mask bit of 0 requires equality.
- R5: The fetch/data and read/write fields restrict the match as encoded above, and 00 in either field disables that check. A channel with both fields at 00 never matches. A nonzero size field must equal the cycle's size.
- R6: With the data condition bit set on channel 1, a match needs both the address conditions and the data condition in the same cycle, where the data condition is `bus_data` equal to the data value on every bit whose data mask bit is 0.
- R7: With a channel 1 size of word or byte, data bits 31:16 are ignored. With byte size, a match on either bits 15:8 or bits 7:0 satisfies the data condition. With size long or any, all 32 bits are compared.
- R8: An external cycle (`bus_ext`=1) never matches while the external enable is 0. When the enable is 1, the size qualifier and the cycle's size are ignored and the full address is compared. The cycle counts as a data access whatever `bus_fetch` says, and the read/write field still applies. Address bits 31:27 of the cycle read as 0, so a channel whose address bits 31:27 are nonzero and unmasked never matches an external cycle.
- R9: An external cycle that matches a channel sets that channel's `ext_flag` bit as well as its `hit_flag` bit. An internal cycle never sets `ext_flag`.
- R10: The flags stay set until a 1 is written to the matching `flag_clr` bit (bits 1:0 clear `hit_flag`, bits 3:2 clear `ext_flag`), and a new match in the same cycle wins over the clear. The flags and `brk_req` take effect on the clock edge that samples the matching cycle. `brk_req` is high for exactly the one clock after a matching cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 32 | Register write value |
| flag_clr | input | 4 | Write-one-to-clear strobes: [1:0] hit flags, [3:2] external flags |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_size | input | 2 | Cycle size: 00 byte, 01 word, 10 long |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_ext | input | 1 | Cycle driven by an external bus master |
| hit_flag | output | 2 | Sticky per-channel match flags |
| ext_flag | output | 2 | Sticky per-channel external-cycle match flags |
| brk_req | output | 1 | One-clock break request |

## Verification
The assertions assume that a cycle is offered only while `bus_valid` is high, and that the bus fields are stable for the clock in which they are sampled. They also assume that software never pulses a clear in a way that would hide a match, since a new match always wins over a clear. The bench drives every bus and register input on the falling edge and holds it through the next rising edge. It offers a cycle at most once between idle clocks and clears the flags only between cycles, so each sampled result belongs to exactly one cycle.

// File: rtl/bus_break_cmp.sv
module bus_break_cmp #(
  parameter int EXT_LINES = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [3:0]  flag_clr,
  input  logic        bus_valid,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_data,
  input  logic [1:0]  bus_size,
  input  logic        bus_write,
  input  logic        bus_fetch,
  input  logic        bus_ext,
  output logic [1:0]  hit_flag,
  output logic [1:0]  ext_flag,
  output logic        brk_req
);
  localparam logic [31:0] EXT_MASK = 32'((64'd1 << EXT_LINES) - 64'd1);

  logic [31:0] a_val [2];
  logic [31:0] a_msk [2];
  logic [6:0]  qual  [2];
  logic [31:0] d_val, d_msk;
  logic        ext_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_val[0] <= '0; a_val[1] <= '0;
      a_msk[0] <= '0; a_msk[1] <= '0;
      qual[0]  <= '0; qual[1]  <= '0;
      d_val    <= '0; d_msk    <= '0;
      ext_en   <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        4'd0: a_val[0] <= wr_data;
        4'd1: a_msk[0] <= wr_data;
        4'd2: qual[0]  <= {1'b0, wr_data[5:0]};
        4'd3: a_val[1] <= wr_data;
        4'd4: a_msk[1] <= wr_data;
        4'd5: qual[1]  <= wr_data[6:0];
        4'd6: d_val    <= wr_data;
        4'd7: d_msk    <= wr_data;
        4'd8: ext_en   <= wr_data[0];
        default: ;
      endcase
    end
  end

  wire [31:0] eff_addr = bus_ext ? (bus_addr & EXT_MASK) : bus_addr;
  wire [31:0] low_care = (bus_ext || bus_size == 2'd0) ? 32'hFFFF_FFFF :
                         (bus_size == 2'd1) ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
  wire [1:0]  size_code = (bus_size == 2'd3) ? 2'd3 : bus_size + 2'd1;
  wire        is_fetch  = bus_fetch && !bus_ext;
  wire        bus_ok    = bus_valid && (!bus_ext || ext_en);

  wire [31:0] d_diff = (d_val ^ bus_data) & ~d_msk;
  wire [1:0]  d_size = qual[1][5:4];
  wire        data_ok = (d_size == 2'd1) ? (d_diff[15:8] == 8'd0 || d_diff[7:0] == 8'd0) :
                        (d_size == 2'd2) ? (d_diff[15:0] == 16'd0) : (d_diff == 32'd0);

  logic [1:0] match;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    wire [1:0] fd = qual[i][1:0];
    wire [1:0] rw = qual[i][3:2];
    wire [1:0] sq = qual[i][5:4];
    wire on     = (fd != 2'd0) || (rw != 2'd0);
    wire fd_ok  = (fd == 2'd0) || (fd == 2'd3) || (fd == 2'd1 && is_fetch) || (fd == 2'd2 && !is_fetch);
    wire rw_ok  = (rw == 2'd0) || (rw == 2'd3) || (rw == 2'd1 && !bus_write) || (rw == 2'd2 && bus_write);
    wire sz_ok  = bus_ext || (sq == 2'd0) || (sq == size_code);
    wire ad_ok  = (((a_val[i] ^ eff_addr) & ~a_msk[i] & low_care) == 32'd0);
    assign match[i] = bus_ok && on && fd_ok && rw_ok && sz_ok && ad_ok && (!qual[i][6] || data_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_flag <= '0;
      ext_flag <= '0;
      brk_req  <= 1'b0;
    end else begin
      hit_flag <= (hit_flag & ~flag_clr[1:0]) | match;
      ext_flag <= (ext_flag & ~flag_clr[3:2]) | (match & {2{bus_ext}});
      brk_req  <= |match;
    end
  end

  // R10
  brk_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (hit_flag != 2'b00));

  // R10
  idle_no_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !brk_req);

  // R10
  sticky_hit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag[0] && !flag_clr[0]) |=> hit_flag[0]);

  // R8
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ext && !ext_en) |=> !brk_req);

  // R9
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag[0]) |-> $past(bus_valid && bus_ext));
endmodule

// File: tb/bus_break_cmp_bench.sv
module bus_break_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  flag_clr = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_write = 1'b0;
  logic        bus_fetch = 1'b0;
  logic        bus_ext = 1'b0;
  logic [1:0]  hit_flag, ext_flag;
  logic        brk_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bus_break_cmp u_bus_break_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_size(bus_size), .bus_write(bus_write), .bus_fetch(bus_fetch), .bus_ext(bus_ext),
    .hit_flag(hit_flag), .ext_flag(ext_flag), .brk_req(brk_req)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] v;
    logic [31:0] m;
    logic [6:0]  q;
    logic [31:0] a;
    logic [1:0]  sz;
    logic        w;
    logic        f;
    logic        exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 32'h1000, 32'h0,    7'h0F, 32'h1003, 2'd2, 1'b0, 1'b0, 1'b1}, // R2
    '{4'd2, 32'h1000, 32'h0,    7'h0F, 32'h1004, 2'd2, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd3, 32'h1000, 32'h0,    7'h0F, 32'h1001, 2'd1, 1'b0, 1'b0, 1'b1}, // R3
    '{4'd3, 32'h1000, 32'h0,    7'h0F, 32'h1002, 2'd1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3, 32'h1000, 32'h0,    7'h0F, 32'h1001, 2'd0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3, 32'h1000, 32'h0,    7'h0F, 32'h1000, 2'd0, 1'b0, 1'b0, 1'b1}, // R3
    '{4'd4, 32'h1000, 32'h00F0, 7'h0F, 32'h10A0, 2'd2, 1'b0, 1'b0, 1'b1}, // R4
    '{4'd4, 32'h1000, 32'h00F0, 7'h0F, 32'h10A4, 2'd2, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd5, 32'h1000, 32'h0,    7'h0D, 32'h1000, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5, 32'h1000, 32'h0,    7'h0D, 32'h1000, 2'd2, 1'b0, 1'b1, 1'b1}, // R5
    '{4'd5, 32'h1000, 32'h0,    7'h08, 32'h1000, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5, 32'h1000, 32'h0,    7'h08, 32'h1000, 2'd2, 1'b1, 1'b0, 1'b1}, // R5
    '{4'd5, 32'h1000, 32'h0,    7'h00, 32'h1000, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5, 32'h1000, 32'h0,    7'h2F, 32'h1000, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5, 32'h1000, 32'h0,    7'h2F, 32'h1000, 2'd1, 1'b0, 1'b0, 1'b1}  // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr(input logic [3:0] bits);
    @(negedge clk);
    flag_clr = bits;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                     input logic w, input logic f, input logic x);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = sz;
    bus_write = w; bus_fetch = f; bus_ext = x;
    @(negedge clk);
    bus_valid = 1'b0; bus_ext = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 hit_flag", {30'd0, hit_flag}, 0);
    check("R1 ext_flag", {30'd0, ext_flag}, 0);
    check("R1 brk_req", {31'd0, brk_req}, 0);
    rst_n = 1'b1;
    cyc(32'h0, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R1 off channels", {30'd0, hit_flag}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(4'd0, VEC[i].v);
      wr(4'd1, VEC[i].m);
      wr(4'd2, {25'd0, VEC[i].q});
      clr(4'hF);
      cyc(VEC[i].a, 32'h0, VEC[i].sz, VEC[i].w, VEC[i].f, 1'b0);
      check($sformatf("R%0d vector %0d hit0", VEC[i].req, i), {31'd0, hit_flag[0]}, {31'd0, VEC[i].exp});
      check($sformatf("R%0d vector %0d brk", VEC[i].req, i), {31'd0, brk_req}, {31'd0, VEC[i].exp});
      if (i == 0) check("R9 internal no ext_flag", {30'd0, ext_flag}, 0);
    end

    // R10 sticky and one-clock pulse
    wr(4'd0, 32'h1000); wr(4'd1, 32'h0); wr(4'd2, 32'h0F);
    clr(4'hF);
    cyc(32'h1000, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R10 brk high", {31'd0, brk_req}, 1);
    @(negedge clk);
    check("R10 brk single clock", {31'd0, brk_req}, 0);
    repeat (3) @(negedge clk);
    check("R10 hit sticky", {30'd0, hit_flag}, 2'b01);
    clr(4'b0010);
    check("R10 clear other bit no effect", {30'd0, hit_flag}, 2'b01);
    clr(4'b0001);
    check("R10 cleared", {30'd0, hit_flag}, 0);

    // R6 data condition
    wr(4'd3, 32'h2000); wr(4'd4, 32'h0); wr(4'd5, 32'h7F);
    wr(4'd6, 32'hDEAD_BEEF); wr(4'd7, 32'h0);
    wr(4'd2, 32'h0);
    clr(4'hF);
    cyc(32'h2000, 32'hDEAD_BEEF, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R6 addr and data match", {30'd0, hit_flag}, 2'b10);
    clr(4'hF);
    cyc(32'h2000, 32'hDEAD_BEEE, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R6 data mismatch", {30'd0, hit_flag}, 0);
    check("R6 no brk", {31'd0, brk_req}, 0);
    cyc(32'h2004, 32'hDEAD_BEEF, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R6 addr mismatch", {30'd0, hit_flag}, 0);
    wr(4'd7, 32'h0000_0001);
    cyc(32'h2000, 32'hDEAD_BEEE, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R6 masked data bit", {30'd0, hit_flag}, 2'b10);

    // R7 word and byte data sizes
    wr(4'd5, 32'h6F); wr(4'd6, 32'h0000_1234); wr(4'd7, 32'hFFFF_0000);
    wr(4'd7, 32'h0);
    clr(4'hF);
    cyc(32'h2000, 32'hFFFF_1234, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R7 word upper ignored", {30'd0, hit_flag}, 2'b10);
    clr(4'hF);
    cyc(32'h2000, 32'h0000_1235, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R7 word low mismatch", {30'd0, hit_flag}, 0);
    wr(4'd5, 32'h5F); wr(4'd6, 32'hAAAA_5A5A);
    cyc(32'h2000, 32'h0000_125A, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R7 byte low lane", {30'd0, hit_flag}, 2'b10);
    clr(4'hF);
    cyc(32'h2000, 32'h0000_5A00, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R7 byte high lane", {30'd0, hit_flag}, 2'b10);
    clr(4'hF);
    cyc(32'h2000, 32'h5A5A_1234, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R7 byte no lane", {30'd0, hit_flag}, 0);
    wr(4'd5, 32'h0);

    // R8 external cycles
    wr(4'd0, 32'h1000); wr(4'd1, 32'h0); wr(4'd2, 32'h3F);
    clr(4'hF);
    cyc(32'h1000, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R8 ext disabled", {30'd0, hit_flag}, 0);
    check("R8 ext disabled brk", {31'd0, brk_req}, 0);
    wr(4'd8, 32'h1);
    cyc(32'h1000, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R8 ext size ignored", {30'd0, hit_flag}, 2'b01);
    check("R9 ext flag ch0", {30'd0, ext_flag}, 2'b01);
    clr(4'b0001);
    check("R10 ext flag kept after hit clear", {30'd0, ext_flag}, 2'b01);
    clr(4'hF);
    cyc(32'h1001, 32'h0, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R8 ext full address", {30'd0, hit_flag}, 0);
    wr(4'd2, 32'h0D);
    cyc(32'h1000, 32'h0, 2'd2, 1'b0, 1'b1, 1'b1);
    check("R8 ext treated as data", {30'd0, hit_flag}, 0);
    wr(4'd2, 32'h07);
    cyc(32'h1000, 32'h0, 2'd2, 1'b1, 1'b0, 1'b1);
    check("R8 ext read/write honoured", {30'd0, hit_flag}, 0);
    wr(4'd2, 32'h0F); wr(4'd0, 32'h0800_1000);
    cyc(32'h0800_1000, 32'h0, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R8 ext high bits unmasked", {30'd0, hit_flag}, 0);
    wr(4'd1, 32'hF800_0000);
    cyc(32'h0800_1000, 32'h0, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R8 ext high bits masked", {30'd0, hit_flag}, 2'b01);

    // R9 channel 1 external flag
    clr(4'hF);
    wr(4'd5, 32'h0F);
    cyc(32'h2000, 32'h0, 2'd2, 1'b0, 1'b0, 1'b1);
    check("R9 ext flag ch1", {30'd0, ext_flag}, 2'b10);
    check("R9 hit flag ch1", {30'd0, hit_flag}, 2'b10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule